// File: doc/BRIEF.md
# Core Low-Power Mode Sequencer

This block sequences one processor core into and out of a low-power state. Software first selects one of four depths: standby, retention, solo power-down or full collapse. When the core then executes wait-for-interrupt, the block steps through a fixed list of handshakes. Each step drives one request level onto one of six control channels and waits until that channel's acknowledge shows the same level. The channels control the core clock gate, the lowered retention voltage, core supply removal, cache-hierarchy standby, the core reset, and a notice to the system resource manager.

Full collapse is taken only if the cluster reports that all cores are idle when wait-for-interrupt arrives. Otherwise the episode runs as a solo power-down. An interrupt that arrives before core supply removal has been requested cancels the episode: every request is dropped at once and the core resumes. A per-step timer raises a sticky error flag if an acknowledge, or the system-ready indication, stays missing too long. When an episode ends, the programmed depth returns to standby.

Top module: `lpm_core_seq`

## Requirements
- R1: After reset, core_run is 1, hs_req is all zero, hs_timeout_err is 0 and armed_mode is 0 (standby).
- R2: When wfi is sampled high while core_run is 1, core_run is 0 from the next cycle on, and the first request raised is clock gate (hs_req bit 0). Mode codes are: 0 standby, 1 retention, 2 solo power-down, 3 full collapse.
- R3: The standby sequence raises clock gate. It then raises cache standby (bit 3) only if all_idle was high at wfi. It waits for irq, drops cache standby, drops clock gate and resumes.
- R4: The retention sequence raises clock gate and then the low-voltage request (bit 1). After irq it drops them in reverse order and resumes.
- R5: The solo power-down sequence raises clock gate, core reset (bit 4) and power-off (bit 2). It waits for irq, drops power-off, waits for sys_ready, drops clock gate and finally releases core reset. It never raises bit 3 or bit 5.
- R6: Full collapse with all_idle high at wfi follows the solo sequence. It additionally raises cache standby and then the resource-manager notice (bit 5) before waiting for irq. After irq it drops them in reverse order, before restoring power.
- R7: Full collapse requested while all_idle is low at wfi runs the solo power-down sequence instead (no bit 5, no bit 3).
- R8: An irq sampled high before the power-off request has been raised cancels the episode. All requests drop together, and once every acknowledge reads zero, core_run returns to 1. Power-off is never raised in that episode.
- R9: Each step advances only when the addressed acknowledge equals its request level. If the sequencer waits on an acknowledge or on sys_ready for TMO_CYC consecutive cycles, hs_timeout_err rises and stays high until reset.
- R10: At the end of every episode, including a cancelled one, armed_mode returns to 0. This overrides a mode write made in the same cycle. A write made while running takes effect on the next episode.
- R11: After power has been restored, the core does not resume while sys_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Write strobe for the programmed depth |
| mode_wr_data | input | 2 | Depth code to program |
| wfi | input | 1 | Core executed wait-for-interrupt |
| irq | input | 1 | Wake-up interrupt (level) |
| all_idle | input | 1 | Every core of the cluster is idle |
| sys_ready | input | 1 | Cache hierarchy and system ready for warm boot |
| hs_ack | input | 6 | Per-channel acknowledge levels |
| hs_req | output | 6 | Per-channel request levels: 0 clock gate, 1 low voltage, 2 power off, 3 cache standby, 4 core reset, 5 resource manager |
| core_run | output | 1 | Core is running (no episode active) |
| hs_timeout_err | output | 1 | Sticky handshake timeout flag |
| armed_mode | output | 2 | Depth that the next episode will use |

## Verification
A wrong step pointer or a wrong choice of effective depth shows up on hs_req within one or two cycles of the slip, because every step issues or retires exactly one request level. A wrongly latched idle flag or a broken cancel condition first appears as an extra or missing bit 2, 3 or 5 request during entry. Stale mode state is visible on armed_mode in the cycle core_run rises. Comparing all outputs every clock against a behavioural model, with acknowledges delayed by a responder, therefore catches a divergence on the first cycle it reaches the ports.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    M_STBY = 2'd0,
    M_RET  = 2'd1,
    M_SOLO = 2'd2,
    M_FULL = 2'd3
  } lpm_mode_e;

  typedef enum logic [2:0] {
    OP_SET  = 3'd0,
    OP_SETI = 3'd1,
    OP_IRQ  = 3'd2,
    OP_SYS  = 3'd3,
    OP_END  = 3'd4
  } lpm_op_e;

  localparam int NCH   = 6;
  localparam int CHW   = $clog2(NCH);
  localparam int CH_CG = 0;
  localparam int CH_VL = 1;
  localparam int CH_PW = 2;
  localparam int CH_CS = 3;
  localparam int CH_RS = 4;
  localparam int CH_RM = 5;

  localparam int MAXSTEPS = 13;
  localparam int PTRW     = $clog2(MAXSTEPS + 1);

  typedef struct packed {
    lpm_op_e          op;
    logic [CHW-1:0]   ch;
    logic             lvl;
  } lpm_step_t;

  function automatic lpm_step_t mk(lpm_op_e op, int ch, logic lvl);
    lpm_step_t s;
    s.op  = op;
    s.ch  = CHW'(ch);
    s.lvl = lvl;
    return s;
  endfunction

endpackage

// File: rtl/lpm_step_rom.sv
module lpm_step_rom
  import lpm_pkg::*;
(
  input  lpm_mode_e       mode,
  input  logic [PTRW-1:0] ptr,
  output lpm_step_t       step
);

  localparam lpm_step_t FIN = '{op: OP_END, ch: '0, lvl: 1'b0};

  always_comb begin
    step = FIN;
    unique case (mode)
      M_STBY: begin
        case (ptr)
          4'd0: step = mk(OP_SET,  CH_CG, 1'b1);
          4'd1: step = mk(OP_SETI, CH_CS, 1'b1);
          4'd2: step = mk(OP_IRQ,  0,     1'b0);
          4'd3: step = mk(OP_SET,  CH_CS, 1'b0);
          4'd4: step = mk(OP_SET,  CH_CG, 1'b0);
          default: step = FIN;
        endcase
      end
      M_RET: begin
        case (ptr)
          4'd0: step = mk(OP_SET, CH_CG, 1'b1);
          4'd1: step = mk(OP_SET, CH_VL, 1'b1);
          4'd2: step = mk(OP_IRQ, 0,     1'b0);
          4'd3: step = mk(OP_SET, CH_VL, 1'b0);
          4'd4: step = mk(OP_SET, CH_CG, 1'b0);
          default: step = FIN;
        endcase
      end
      M_SOLO: begin
        case (ptr)
          4'd0: step = mk(OP_SET, CH_CG, 1'b1);
          4'd1: step = mk(OP_SET, CH_RS, 1'b1);
          4'd2: step = mk(OP_SET, CH_PW, 1'b1);
          4'd3: step = mk(OP_IRQ, 0,     1'b0);
          4'd4: step = mk(OP_SET, CH_PW, 1'b0);
          4'd5: step = mk(OP_SYS, 0,     1'b0);
          4'd6: step = mk(OP_SET, CH_CG, 1'b0);
          4'd7: step = mk(OP_SET, CH_RS, 1'b0);
          default: step = FIN;
        endcase
      end
      M_FULL: begin
        case (ptr)
          4'd0:  step = mk(OP_SET, CH_CG, 1'b1);
          4'd1:  step = mk(OP_SET, CH_RS, 1'b1);
          4'd2:  step = mk(OP_SET, CH_PW, 1'b1);
          4'd3:  step = mk(OP_SET, CH_CS, 1'b1);
          4'd4:  step = mk(OP_SET, CH_RM, 1'b1);
          4'd5:  step = mk(OP_IRQ, 0,     1'b0);
          4'd6:  step = mk(OP_SET, CH_RM, 1'b0);
          4'd7:  step = mk(OP_SET, CH_CS, 1'b0);
          4'd8:  step = mk(OP_SET, CH_PW, 1'b0);
          4'd9:  step = mk(OP_SYS, 0,     1'b0);
          4'd10: step = mk(OP_SET, CH_CG, 1'b0);
          4'd11: step = mk(OP_SET, CH_RS, 1'b0);
          default: step = FIN;
        endcase
      end
      default: step = FIN;
    endcase
  end

endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  lpm_mode_e wr_mode,
  input  logic      ep_done,
  output lpm_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= M_STBY;
    else if (ep_done) mode_q <= M_STBY;
    else if (wr_en)   mode_q <= wr_mode;
  end

endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic err_q
);

  localparam int CW  = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (waiting) begin
      if (cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LIM) err_q <= 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/lpm_core_seq.sv
module lpm_core_seq
  import lpm_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_wr_en,
  input  logic [1:0]     mode_wr_data,
  input  logic           wfi,
  input  logic           irq,
  input  logic           all_idle,
  input  logic           sys_ready,
  input  logic [NCH-1:0] hs_ack,
  output logic [NCH-1:0] hs_req,
  output logic           core_run,
  output logic           hs_timeout_err,
  output logic [1:0]     armed_mode
);

  typedef enum logic [1:0] {S_RUN, S_STEP, S_ABORT} seq_st_e;

  seq_st_e         state_q;
  logic [PTRW-1:0] ptr_q;
  lpm_mode_e       eff_q;
  lpm_mode_e       mode_q;
  logic            idle_q;
  logic            past_q;
  logic [NCH-1:0]  req_q;
  lpm_step_t       step;

  logic abort_go, ep_done, waiting, skip, issued, matched;

  lpm_step_rom u_rom (.mode(eff_q), .ptr(ptr_q), .step(step));

  lpm_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr_en(mode_wr_en),
    .wr_mode(lpm_mode_e'(mode_wr_data)), .ep_done(ep_done), .mode_q(mode_q)
  );

  lpm_wait_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst), .waiting(waiting), .err_q(hs_timeout_err)
  );

  always_comb begin
    skip     = (step.op == OP_SETI) && !idle_q;
    issued   = (req_q[step.ch] == step.lvl);
    matched  = (hs_ack[step.ch] == step.lvl);
    abort_go = (state_q == S_STEP) && irq && !past_q && !req_q[CH_PW] &&
               (step.op != OP_IRQ);
    ep_done  = ((state_q == S_STEP) && !abort_go && (step.op == OP_END)) ||
               ((state_q == S_ABORT) && (req_q == '0) && (hs_ack == '0));
    waiting  = 1'b0;
    if (state_q == S_STEP && !abort_go) begin
      if ((step.op == OP_SET || step.op == OP_SETI) && !skip)
        waiting = issued && !matched;
      else if (step.op == OP_SYS)
        waiting = !sys_ready;
    end else if (state_q == S_ABORT) begin
      waiting = (req_q == '0) && (hs_ack != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_RUN;
      ptr_q   <= '0;
      eff_q   <= M_STBY;
      idle_q  <= 1'b0;
      past_q  <= 1'b0;
      req_q   <= '0;
    end else begin
      unique case (state_q)
        S_RUN: begin
          if (wfi) begin
            state_q <= S_STEP;
            ptr_q   <= '0;
            eff_q   <= (mode_q == M_FULL && !all_idle) ? M_SOLO : mode_q;
            idle_q  <= all_idle;
            past_q  <= 1'b0;
          end
        end
        S_STEP: begin
          if (abort_go) begin
            state_q <= S_ABORT;
          end else begin
            unique case (step.op)
              OP_SET, OP_SETI: begin
                if (skip)          ptr_q <= ptr_q + PTRW'(1);
                else if (!issued)  req_q[step.ch] <= step.lvl;
                else if (matched)  ptr_q <= ptr_q + PTRW'(1);
              end
              OP_IRQ: begin
                if (irq) begin
                  past_q <= 1'b1;
                  ptr_q  <= ptr_q + PTRW'(1);
                end
              end
              OP_SYS: begin
                if (sys_ready) ptr_q <= ptr_q + PTRW'(1);
              end
              default: state_q <= S_RUN;
            endcase
          end
        end
        S_ABORT: begin
          if (req_q != '0)       req_q   <= '0;
          else if (hs_ack == '0) state_q <= S_RUN;
        end
        default: state_q <= S_RUN;
      endcase
    end
  end

  assign hs_req     = req_q;
  assign core_run   = (state_q == S_RUN);
  assign armed_mode = mode_q;

  // R10
  revert_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_run) |-> armed_mode == 2'd0);

  // R8
  run_clean_chk: assert property (@(posedge clk) disable iff (rst)
    core_run |-> hs_req == '0);

  // R5
  pwr_guard_chk: assert property (@(posedge clk) disable iff (rst)
    hs_req[CH_PW] |-> (hs_req[CH_RS] && hs_req[CH_CG]));

  // R6
  rm_guard_chk: assert property (@(posedge clk) disable iff (rst)
    hs_req[CH_RM] |-> (hs_req[CH_PW] && hs_req[CH_CS]));

  // R4
  vl_guard_chk: assert property (@(posedge clk) disable iff (rst)
    hs_req[CH_VL] |-> hs_req[CH_CG]);

  // R2
  first_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_run) |-> hs_req == '0);

endmodule

// File: tb/lpm_core_seq_test.sv
module lpm_core_seq_test;

  localparam int TMO = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr_en = 1'b0;
  logic [1:0] mode_wr_data = 2'd0;
  logic       wfi = 1'b0, irq = 1'b0, all_idle = 1'b0, sys_ready = 1'b1;
  logic [5:0] hs_ack = 6'd0;
  logic [5:0] hs_req;
  logic       core_run, hs_timeout_err;
  logic [1:0] armed_mode;

  always #4 clk = ~clk;

  lpm_core_seq #(.TMO_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .wfi(wfi), .irq(irq), .all_idle(all_idle), .sys_ready(sys_ready),
    .hs_ack(hs_ack), .hs_req(hs_req), .core_run(core_run),
    .hs_timeout_err(hs_timeout_err), .armed_mode(armed_mode)
  );

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  logic  stall [6];
  int    acnt [6];
  int    lat = 1;
  logic  saw_pw, saw_cs, saw_rm;

  // acknowledge responder
  always @(negedge clk) begin
    for (int i = 0; i < 6; i++) begin
      if (hs_ack[i] != hs_req[i] && !stall[i]) begin
        if (acnt[i] >= lat) begin hs_ack[i] = hs_req[i]; acnt[i] = 0; end
        else acnt[i]++;
      end else acnt[i] = 0;
    end
    if (hs_req[2]) saw_pw = 1'b1;
    if (hs_req[3]) saw_cs = 1'b1;
    if (hs_req[5]) saw_rm = 1'b1;
  end

  // behavioural reference model
  int   q[$];
  int   m_st, wcnt;
  logic [5:0] m_req;
  logic m_err, m_idle, m_past;
  logic [1:0] m_mode;

  function automatic void load(logic [1:0] md, logic idle);
    q.delete();
    if (md == 2'd3 && !idle) md = 2'd2;
    case (md)
      2'd0: q = '{101, 231, 300, 130, 100, 500};
      2'd1: q = '{101, 111, 300, 110, 100, 500};
      2'd2: q = '{101, 141, 121, 300, 120, 400, 100, 140, 500};
      default: q = '{101, 141, 121, 131, 151, 300, 150, 130, 120, 400, 100, 140, 500};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_req = 0; m_err = 0; m_mode = 0; wcnt = 0; q.delete();
      m_idle = 0; m_past = 0;
    end else begin
      logic [1:0] nm;
      logic w;
      int op, ch, lv;
      w = 1'b0;
      nm = mode_wr_en ? mode_wr_data : m_mode;
      if (m_st == 0) begin
        if (wfi) begin load(m_mode, all_idle); m_idle = all_idle; m_past = 0; m_st = 1; end
      end else if (m_st == 1) begin
        op = q[0] / 100; ch = (q[0] / 10) % 10; lv = q[0] % 10;
        if (irq && !m_past && !m_req[2] && op != 3) m_st = 2;
        else if (op == 1 || op == 2) begin
          if (op == 2 && !m_idle) void'(q.pop_front());
          else if (m_req[ch] != lv[0]) m_req[ch] = lv[0];
          else if (hs_ack[ch] == lv[0]) void'(q.pop_front());
          else w = 1'b1;
        end else if (op == 3) begin
          if (irq) begin m_past = 1; void'(q.pop_front()); end
        end else if (op == 4) begin
          if (sys_ready) void'(q.pop_front()); else w = 1'b1;
        end else begin
          m_st = 0; nm = 0; void'(q.pop_front());
        end
      end else begin
        if (m_req != 0) m_req = 0;
        else if (hs_ack == 0) begin m_st = 0; nm = 0; end
        else w = 1'b1;
      end
      m_mode = nm;
      if (w) begin wcnt++; if (wcnt >= TMO) m_err = 1; end else wcnt = 0;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      chk(cur_req, {21'd0, core_run, hs_timeout_err, armed_mode, hs_req},
                   {21'd0, (m_st == 0), m_err, m_mode, m_req});
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic episode(input logic [1:0] md, input logic idle,
                         input int irq_after, input int sys_hold, input string tag);
    int n;
    cur_req = tag;
    @(negedge clk); mode_wr_en = 1; mode_wr_data = md; all_idle = idle;
    @(negedge clk); mode_wr_en = 0; wfi = 1;
    saw_pw = 0; saw_cs = 0; saw_rm = 0;
    @(negedge clk); wfi = 0;
    chk("R2", {31'd0, core_run}, 32'd0);
    if (sys_hold > 0) sys_ready = 0;
    repeat (irq_after) @(negedge clk);
    irq = 1;
    if (sys_hold > 0) begin
      repeat (8) @(negedge clk);
      // R11: power restored but still held until system ready
      chk("R11", {30'd0, core_run, hs_req[2]}, 32'd0);
      repeat (sys_hold - 8) @(negedge clk);
      sys_ready = 1;
    end
    n = 0;
    while (!core_run && n < 500) begin @(negedge clk); n++; end
    irq = 0;
    // R10: depth reverts to standby
    chk("R10", {30'd0, armed_mode}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin stall[i] = 0; acnt[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1", {23'd0, core_run, hs_timeout_err, armed_mode, hs_req}, {23'd0, 1'b1, 1'b0, 2'd0, 6'd0});

    episode(2'd0, 1'b1, 20, 0, "R3");
    chk("R3", {31'd0, saw_cs}, 32'd1);
    episode(2'd0, 1'b0, 20, 0, "R3");
    chk("R3", {31'd0, saw_cs}, 32'd0);

    lat = 3;
    episode(2'd1, 1'b0, 30, 0, "R4");
    lat = 1;

    episode(2'd2, 1'b1, 30, 12, "R5");
    chk("R5", {29'd0, saw_pw, saw_cs, saw_rm}, {29'd0, 3'b100});

    episode(2'd3, 1'b1, 40, 0, "R6");
    chk("R6", {29'd0, saw_pw, saw_cs, saw_rm}, {29'd0, 3'b111});

    episode(2'd3, 1'b0, 40, 0, "R7");
    chk("R7", {29'd0, saw_pw, saw_cs, saw_rm}, {29'd0, 3'b100});

    episode(2'd2, 1'b0, 1, 0, "R8");
    chk("R8", {31'd0, saw_pw}, 32'd0);
    chk("R8", {31'd0, core_run}, 32'd1);

    // R10: write while running is used by the next episode
    cur_req = "R10";
    @(negedge clk); mode_wr_en = 1; mode_wr_data = 2'd1;
    @(negedge clk); mode_wr_en = 0;
    chk("R10", {30'd0, armed_mode}, 32'd1);

    // R9: stalled acknowledge raises sticky error
    stall[1] = 1;
    cur_req = "R9";
    @(negedge clk); wfi = 1;
    @(negedge clk); wfi = 0;
    repeat (TMO + 10) @(negedge clk);
    chk("R9", {31'd0, hs_timeout_err}, 32'd1);
    stall[1] = 0;
    repeat (5) @(negedge clk);
    irq = 1;
    repeat (20) @(negedge clk);
    irq = 0;
    chk("R9", {30'd0, core_run, hs_timeout_err}, 32'd3);
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule